// File: doc/BRIEF.md
# Staged Control Register Trigger Unit

This block owns a two-bit control register that a host fills through a plain write port. Host writes land in a shadow copy. A separate update strobe commits the shadow into the active copy. When the commit changes a bit, the block compares the old and new active values and turns the change into an action on one of two internal subsystems.

The sync bit drives the clock distribution. While the committed sync bit is 1, the distribution stays stalled. When a commit clears the bit, a one-cycle sync pulse is issued.

The calibrate bit starts a timed calibration, but only when a commit raises it from 0 to 1 and the system clock PLL enable input is high. The calibration is modelled as a cycle counter of programmable length. While it runs, the internal clock is stalled and the done flag reads 0. To calibrate again, the host has to commit a 0 and then commit a 1.

Top module: `stage_trig_top`

## Requirements
- R1: After reset:
  - both the shadow and active register bits are 0;
  - distStall, syncPulse and clkStall are 0;
  - calDone is 1.
- R2: A host write (wrEn high at a clock edge) changes only the shadow copy. While updStrobe is low, the ctrlActive readback stays unchanged.
- R3: At a clock edge with updStrobe high, ctrlActive takes the shadow value held before that edge. Bit 0 is the calibrate bit and bit 1 is the sync bit. A write in the same cycle reaches the active copy only at a later update.
- R4: distStall equals the committed sync bit (ctrlActive bit 1). It is therefore high for as long as that bit is 1.
- R5: syncPulse is high for exactly one cycle, the cycle right after an update edge that changes the sync bit from 1 to 0. It is low at all other times.
- R6: An update edge that changes the calibrate bit from 0 to 1 while pllEnable is high starts a calibration. clkStall is then high for exactly CAL_CYCLES cycles, starting in the cycle after that edge.
- R7: A 0-to-1 commit of the calibrate bit while pllEnable is low starts no calibration.
- R8: Committing a 1 to a calibrate bit that is already 1 starts nothing. Recalibration needs a commit of 0 followed by a commit of 1.
- R9: A calibrate rising commit that arrives while a calibration is running is ignored. The running calibration ends on its original schedule.
- R10: calDone is 1 exactly when no calibration is running (the inverse of clkStall).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write enable into the shadow copy |
| wrData | input | 2 | Host write data (bit 0 calibrate, bit 1 sync) |
| updStrobe | input | 1 | Commit shadow copy into the active copy |
| pllEnable | input | 1 | System clock PLL enable; qualifies calibration start |
| ctrlActive | output | 2 | Readback of the committed register |
| distStall | output | 1 | Clock distribution stall |
| syncPulse | output | 1 | One-cycle distribution sync pulse |
| clkStall | output | 1 | Internal clock stall, high during calibration |
| calDone | output | 1 | High when no calibration is running |

## Verification
The bench builds the block with CAL_CYCLES set to 12, far below the default of about one millisecond at 250 MHz. This lets the random phase complete hundreds of calibrations. It also makes many calibrate commits land inside a running calibration, or with the PLL enable low. The short window lets directed runs count every stall cycle exactly. It also lets the bench commit a second rising edge in the middle of a calibration and confirm that the original end cycle still holds.

// File: rtl/stage_trig_pkg.sv
package stage_trig_pkg;

  localparam int CTRL_W   = 2;
  localparam int CAL_BIT  = 0;
  localparam int SYNC_BIT = 1;

  typedef struct packed {
    logic calRise;
    logic syncFall;
  } trigStrobes_t;

  typedef enum logic {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } calState_t;

endpackage

// File: rtl/stage_trig_ctrl.sv
module stage_trig_ctrl
  import stage_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              updStrobe,
  output logic [CTRL_W-1:0] activeReg,
  output trigStrobes_t      strobes
);

  logic [CTRL_W-1:0] shadowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowReg <= '0;
      activeReg <= '0;
    end else begin
      if (wrEn)      shadowReg <= wrData;
      if (updStrobe) activeReg <= shadowReg;
    end
  end

  // Edge detection: compare the value being committed with the current active value.
  always_comb begin
    strobes.calRise  = updStrobe &  shadowReg[CAL_BIT]  & ~activeReg[CAL_BIT];
    strobes.syncFall = updStrobe & ~shadowReg[SYNC_BIT] &  activeReg[SYNC_BIT];
  end

endmodule

// File: rtl/stage_trig_path.sv
module stage_trig_path
  import stage_trig_pkg::*;
#(
  parameter int CAL_CYCLES = 250000
) (
  input  logic         clk,
  input  logic         rstN,
  input  trigStrobes_t strobes,
  input  logic         pllEnable,
  output logic         syncPulse,
  output logic         calBusy
);

  localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_LEFT = CNT_W'(CAL_CYCLES - 1);

  calState_t         calState;
  logic [CNT_W-1:0]  cyclesLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPulse <= 1'b0;
    end else begin
      syncPulse <= strobes.syncFall;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calState   <= CAL_IDLE;
      cyclesLeft <= '0;
    end else begin
      case (calState)
        CAL_IDLE: begin
          if (strobes.calRise && pllEnable) begin
            calState   <= CAL_RUN;
            cyclesLeft <= LAST_LEFT;
          end
        end
        CAL_RUN: begin
          if (cyclesLeft == '0) calState <= CAL_IDLE;
          else                  cyclesLeft <= cyclesLeft - 1'b1;
        end
        default: calState <= CAL_IDLE;
      endcase
    end
  end

  assign calBusy = (calState == CAL_RUN);

endmodule

// File: rtl/stage_trig_top.sv
module stage_trig_top
  import stage_trig_pkg::*;
#(
  parameter int CAL_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrData,
  input  logic       updStrobe,
  input  logic       pllEnable,
  output logic [1:0] ctrlActive,
  output logic       distStall,
  output logic       syncPulse,
  output logic       clkStall,
  output logic       calDone
);

  trigStrobes_t strobes;
  logic         calBusy;

  stage_trig_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .updStrobe (updStrobe),
    .activeReg (ctrlActive),
    .strobes   (strobes)
  );

  stage_trig_path #(.CAL_CYCLES(CAL_CYCLES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pllEnable (pllEnable),
    .syncPulse (syncPulse),
    .calBusy   (calBusy)
  );

  assign distStall = ctrlActive[SYNC_BIT];
  assign clkStall  = calBusy;
  assign calDone   = ~calBusy;

endmodule

// File: rtl/stage_trig_chk.sv
module stage_trig_chk #(
  parameter int CAL_CYCLES = 250000
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrData,
  input logic       updStrobe,
  input logic       pllEnable,
  input logic [1:0] ctrlActive,
  input logic       distStall,
  input logic       syncPulse,
  input logic       clkStall,
  input logic       calDone
);

  logic [31:0] stallRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         stallRun <= '0;
    else if (clkStall) stallRun <= stallRun + 1;
    else               stallRun <= '0;
  end

  assert_active_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |=> $stable(ctrlActive));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse);

  assert_pulse_on_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |-> $fell(distStall));

  assert_cal_committed_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStall) |-> ($past(updStrobe) && ctrlActive[0]));

  assert_cal_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkStall) |-> (stallRun == 32'(CAL_CYCLES)));

  assert_cal_needs_pll_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStall) |-> $past(pllEnable));

endmodule

bind stage_trig_top stage_trig_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (.*);

// File: tb/sim_stage_trig_top.sv
module sim_stage_trig_top;

  localparam int CAL = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrData = '0;
  logic       updStrobe = 1'b0;
  logic       pllEnable = 1'b1;
  logic [1:0] ctrlActive;
  logic       distStall, syncPulse, clkStall, calDone;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stage_trig_top #(.CAL_CYCLES(CAL)) u0 (.*);

  // Reference model built from the requirements
  logic [1:0] mShadow, mActive;
  logic       mPulse, mBusy;
  int         mElapsed;

  function automatic logic expRise(logic [1:0] sh, logic [1:0] ac, logic up);
    return up && sh[0] && !ac[0];
  endfunction

  function automatic logic expFall(logic [1:0] sh, logic [1:0] ac, logic up);
    return up && !sh[1] && ac[1];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mShadow <= '0; mActive <= '0; mPulse <= 1'b0; mBusy <= 1'b0; mElapsed <= 0;
    end else begin
      if (wrEn) mShadow <= wrData;
      if (updStrobe) mActive <= mShadow;
      mPulse <= expFall(mShadow, mActive, updStrobe);
      if (mBusy) begin
        mElapsed <= mElapsed + 1;
        if (mElapsed + 1 == CAL) mBusy <= 1'b0;
      end else if (expRise(mShadow, mActive, updStrobe) && pllEnable) begin
        mBusy <= 1'b1;
        mElapsed <= 0;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(32'(ctrlActive), 32'(mActive), "R3 ctrlActive");
      check(32'(distStall), 32'(mActive[1]), "R4 distStall");
      check(32'(syncPulse), 32'(mPulse), "R5 syncPulse");
      check(32'(clkStall), 32'(mBusy), "R6 clkStall");
      check(32'(calDone), 32'(!mBusy), "R10 calDone");
    end
  end

  task automatic cyc(input logic w, input logic [1:0] d, input logic u);
    wrEn = w; wrData = d; updStrobe = u;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; updStrobe = 1'b0;
  endtask

  task automatic commit(input logic [1:0] d);
    cyc(1'b1, d, 1'b0);
    cyc(1'b0, 2'b00, 1'b1);
  endtask

  task automatic countStall(input int start, input string req);
    int n = start;
    while (clkStall && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(32'(n), 32'(CAL), req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(32'(ctrlActive), 0, "R1 ctrlActive");
    check(32'(distStall), 0, "R1 distStall");
    check(32'(syncPulse), 0, "R1 syncPulse");
    check(32'(clkStall), 0, "R1 clkStall");
    check(32'(calDone), 1, "R1 calDone");

    // R2 write without update
    cyc(1'b1, 2'b10, 1'b0);
    check(32'(ctrlActive), 0, "R2 no commit");
    // R3 commit
    cyc(1'b0, 2'b00, 1'b1);
    check(32'(ctrlActive), 2, "R3 committed");
    check(32'(distStall), 1, "R4 stalled");
    // R5 release
    commit(2'b00);
    check(32'(syncPulse), 1, "R5 pulse");
    @(negedge clk);
    check(32'(syncPulse), 0, "R5 pulse width");

    // R6 calibration length
    pllEnable = 1'b1;
    commit(2'b01);
    check(32'(calDone), 0, "R10 busy");
    countStall(0, "R6 stall cycles");
    check(32'(calDone), 1, "R10 finished");

    // R8 re-commit of 1 without 0
    commit(2'b01);
    check(32'(clkStall), 0, "R8 no restart");

    // R7 pll disabled
    commit(2'b00);
    pllEnable = 1'b0;
    commit(2'b01);
    check(32'(clkStall), 0, "R7 pll off");
    pllEnable = 1'b1;

    // R9 rising edge during calibration
    commit(2'b00);
    commit(2'b01);
    commit(2'b00);
    commit(2'b01);
    countStall(4, "R9 original schedule");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      wrEn      = ($urandom % 10) < 4;
      wrData    = 2'($urandom % 4);
      updStrobe = ($urandom % 10) < 3;
      pllEnable = ($urandom % 4) != 0;
      @(negedge clk);
    end
    wrEn = 1'b0; updStrobe = 1'b0;
    repeat (CAL + 2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule